// File: doc/BRIEF.md
# Processor Fault Escalation Unit

This unit sits next to a small processor pipeline and turns single-cycle fault event pulses into exception requests. Each pulse carries a cause code and may carry an address. The unit places every accepted event in one of four classes: hard, memory-management, bus or usage. It then decides whether the class's own handler may be entered, or whether the event must be raised as a hard fault instead.

A configurable class reaches its own handler only when that class is enabled and its priority is numerically below the current execution priority. In every other case the event becomes a hard fault and the forced flag is recorded. A bus error during a vector table fetch, a breakpoint taken while debug is off, and a supervisor call issued inside its own handler always go to the hard class. The hard class has a fixed priority above every configurable class. Only the fault-mask input can block it.

Status bits record each cause and stay set until software clears them. Two address registers capture the faulting address for memory-management faults and for bus faults. A small register port reads this state and clears it with write-one-to-clear.

Top module: `fault_escalator`

## Requirements
- R1: After reset, exc_req is 0, exc_vec is 0, and the status word, both address registers and both valid flags read 0.
- R2: ev_cause bit positions are: 0 undefined instruction, 1 divide by zero, 2 unaligned access, 3 protection violation, 4 data bus error, 5 vector-fetch bus error, 6 breakpoint with debug off, 7 supervisor call inside the supervisor handler. Bits 0-2 form the usage class, bit 3 the memory-management class, bit 4 the bus class, and bits 5-7 the hard class.
- R3: A configurable-class event whose class enable is 0 is raised as a hard fault and sets the forced flag, which is status bit 8.
- R4: A configurable-class event whose class priority is not numerically lower than cur_prio is raised as a hard fault and sets the forced flag, even when the class is enabled.
- R5: A vector-fetch bus error (bit 5) always produces a hard-fault request, even when en_bus is 1. It sets no bus address capture.
- R6: A breakpoint event (bit 6) or a nested supervisor call (bit 7) produces a hard-fault request and sets its own status bit.
- R7: When trap_div is 0, a divide-by-zero event is ignored. When trap_unal is 0, an unaligned-access event is ignored. An ignored event produces no request and sets no status bit.
- R8: When fault_mask is 1, no hard-fault request is made, whether the hard fault is direct or escalated. A configurable class that may be taken is still requested, and status is still recorded.
- R9: Vector numbers are hard 3, memory-management 4, bus 5 and usage 6. exc_req and exc_vec appear in the cycle after the event and last one cycle. exc_vec is 0 when there is no request.
- R10: When several classes are requested in the same cycle, the winner is chosen in this order: hard, then memory-management, then bus, then usage.
- R11: Status bits [7:0] are sticky cause flags. Writing reg_sel=0 with reg_wr=1 clears every status bit whose wdata bit is 1. A new event in the same cycle as the clear leaves its bit set.
- R12: A protection violation captures ev_addr into the memory-management address register and sets status bit 9. A data bus error captures ev_addr into the bus address register and sets status bit 10. While a valid flag is set and is not being cleared, its address register does not change.
- R13: reg_rdata is combinational from reg_sel: 0 gives the status word, zero-extended; 1 gives the memory-management address; 2 gives the bus address; 3 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_cause | input | 8 | Fault event pulses, one bit per cause |
| ev_addr | input | AW | Faulting address that goes with the events |
| en_mem | input | 1 | Memory-management class enable |
| en_bus | input | 1 | Bus class enable |
| en_usage | input | 1 | Usage class enable |
| trap_div | input | 1 | Divide-by-zero trap enable |
| trap_unal | input | 1 | Unaligned-access trap enable |
| prio_mem | input | PW | Memory-management class priority |
| prio_bus | input | PW | Bus class priority |
| prio_usage | input | PW | Usage class priority |
| cur_prio | input | PW | Current execution priority |
| fault_mask | input | 1 | Blocks hard-fault requests |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, write-one-to-clear on the status word |
| reg_wdata | input | AW | Clear mask |
| reg_rdata | output | AW | Selected register contents |
| exc_req | output | 1 | Exception request |
| exc_vec | output | 8 | Vector number of the request |

## Verification
The bench targets escalation when a class is enabled but its priority equals cur_prio; a design that compares with <= instead of < would enter the configurable handler and never set the forced flag. A vector-fetch bus error is sent with the bus class fully enabled, where a design that treats it as an ordinary bus fault would return vector 5. Same-cycle collisions are covered in three forms: several classes at once, a clear meeting a fresh event, and a second address arriving while the valid flag is set. A wrong implementation would return the wrong vector, lose a sticky bit, or overwrite the frozen address. Trap-disabled events and the fault mask are checked at the request and status outputs.

// File: rtl/fault_escalator.sv
module fault_escalator #(
  parameter int AW = 32,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    ev_cause,
  input  logic [AW-1:0] ev_addr,
  input  logic          en_mem,
  input  logic          en_bus,
  input  logic          en_usage,
  input  logic          trap_div,
  input  logic          trap_unal,
  input  logic [PW-1:0] prio_mem,
  input  logic [PW-1:0] prio_bus,
  input  logic [PW-1:0] prio_usage,
  input  logic [PW-1:0] cur_prio,
  input  logic          fault_mask,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          exc_req,
  output logic [7:0]    exc_vec
);
  localparam int SW = 11;
  localparam logic [7:0] V_HARD = 8'd3, V_MEM = 8'd4, V_BUS = 8'd5, V_USE = 8'd6;

  logic [SW-1:0] st;
  logic [AW-1:0] maddr, baddr;

  logic [7:0] ev;
  assign ev = ev_cause & ~{5'b0, ~trap_unal, ~trap_div, 1'b0};

  logic mem_f, bus_f, use_f, mem_ok, bus_ok, use_ok, esc, hard, req;
  assign mem_f  = ev[3];
  assign bus_f  = ev[4];
  assign use_f  = |ev[2:0];
  assign mem_ok = en_mem   && (prio_mem   < cur_prio);
  assign bus_ok = en_bus   && (prio_bus   < cur_prio);
  assign use_ok = en_usage && (prio_usage < cur_prio);
  assign esc    = (mem_f && !mem_ok) || (bus_f && !bus_ok) || (use_f && !use_ok);
  assign hard   = (|ev[7:5]) || esc;
  assign req    = (hard && !fault_mask) || (mem_f && mem_ok) || (bus_f && bus_ok) || (use_f && use_ok);

  logic [7:0] vec;
  always_comb begin
    if (hard && !fault_mask)  vec = V_HARD;
    else if (mem_f && mem_ok) vec = V_MEM;
    else if (bus_f && bus_ok) vec = V_BUS;
    else if (use_f && use_ok) vec = V_USE;
    else                      vec = 8'd0;
  end

  logic [SW-1:0] clr;
  assign clr = (reg_wr && reg_sel == 2'd0) ? reg_wdata[SW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= '0;
      maddr   <= '0;
      baddr   <= '0;
      exc_req <= 1'b0;
      exc_vec <= 8'd0;
    end else begin
      st[7:0] <= (st[7:0] & ~clr[7:0]) | ev;
      st[8]   <= (st[8]  && !clr[8])  || esc;
      st[9]   <= (st[9]  && !clr[9])  || mem_f;
      st[10]  <= (st[10] && !clr[10]) || bus_f;
      if (mem_f && (!st[9] || clr[9]))   maddr <= ev_addr;
      if (bus_f && (!st[10] || clr[10])) baddr <= ev_addr;
      exc_req <= req;
      exc_vec <= vec;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0:    reg_rdata[SW-1:0] = st;
      2'd1:    reg_rdata = maddr;
      2'd2:    reg_rdata = baddr;
      default: reg_rdata = '0;
    endcase
  end

  AST_DISABLED_ESCALATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cause == 8'h08 && !en_mem && !fault_mask) |=> (exc_req && exc_vec == 8'd3)); // R3
  AST_VECFETCH_HARD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cause[5] && !fault_mask) |=> (exc_req && exc_vec == 8'd3)); // R5
  AST_TRAP_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cause == 8'h02 && !trap_div) |=> !exc_req); // R7
  AST_MASK_BLOCKS_HARD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_mask && ev_cause[4:0] == 5'd0) |=> !exc_req); // R8
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_vec >= 8'd3 && exc_vec <= 8'd6)); // R9
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> (exc_vec == 8'd0)); // R9
  AST_MADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st[9]) && !$past(clr[9])) |-> (maddr == $past(maddr))); // R12
  AST_BADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st[10]) && !$past(clr[10])) |-> (baddr == $past(baddr))); // R12
endmodule

// File: tb/sim_fault_escalator.sv
module sim_fault_escalator;
  localparam int AW = 32;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ev_cause = '0;
  logic [AW-1:0] ev_addr = '0;
  logic en_mem = 0, en_bus = 0, en_usage = 0, trap_div = 0, trap_unal = 0, fault_mask = 0;
  logic [PW-1:0] prio_mem = '0, prio_bus = '0, prio_usage = '0, cur_prio = '1;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic exc_req;
  logic [7:0] exc_vec;

  always #5 clk = ~clk;

  fault_escalator #(.AW(AW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_cause(ev_cause), .ev_addr(ev_addr),
    .en_mem(en_mem), .en_bus(en_bus), .en_usage(en_usage),
    .trap_div(trap_div), .trap_unal(trap_unal),
    .prio_mem(prio_mem), .prio_bus(prio_bus), .prio_usage(prio_usage),
    .cur_prio(cur_prio), .fault_mask(fault_mask),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .exc_req(exc_req), .exc_vec(exc_vec));

  int checks = 0, failures = 0;
  bit done = 0;

  logic [10:0] m_st;
  logic [AW-1:0] m_ma, m_ba;
  logic m_req;
  logic [7:0] m_vec;

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] expect_read(input logic [1:0] s);
    case (s)
      2'd0: return {{(AW-11){1'b0}}, m_st};
      2'd1: return m_ma;
      2'd2: return m_ba;
      default: return '0;
    endcase
  endfunction

  task automatic model_step();
    logic [7:0] e;
    logic mf, bf, uf, mo, bo, uo, es, hd;
    logic [10:0] c;
    e = ev_cause;
    if (!trap_div)  e[1] = 1'b0;
    if (!trap_unal) e[2] = 1'b0;
    mf = e[3]; bf = e[4]; uf = e[0] | e[1] | e[2];
    mo = en_mem && prio_mem < cur_prio;
    bo = en_bus && prio_bus < cur_prio;
    uo = en_usage && prio_usage < cur_prio;
    es = (mf && !mo) || (bf && !bo) || (uf && !uo);
    hd = e[5] || e[6] || e[7] || es;
    c = (reg_wr && reg_sel == 0) ? reg_wdata[10:0] : 11'd0;
    if (mf && (!m_st[9] || c[9]))  m_ma = ev_addr;
    if (bf && (!m_st[10] || c[10])) m_ba = ev_addr;
    m_st = (m_st & ~c) | {bf, mf, es, e};
    m_req = 1'b1;
    if (hd && !fault_mask) m_vec = 8'd3;
    else if (mf && mo) m_vec = 8'd4;
    else if (bf && bo) m_vec = 8'd5;
    else if (uf && uo) m_vec = 8'd6;
    else begin m_vec = 8'd0; m_req = 1'b0; end
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_step();
    #1;
    check({tag, " req"}, AW'(exc_req), AW'(m_req));
    check({tag, " vec"}, AW'(exc_vec), AW'(m_vec));
    check({tag, " rd"}, reg_rdata, expect_read(reg_sel));
    @(negedge clk);
    ev_cause = '0;
    reg_wr = 0;
  endtask

  task automatic ev(input logic [7:0] c, input logic [AW-1:0] a, input string tag);
    ev_cause = c; ev_addr = a;
    cycle(tag);
  endtask

  task automatic clear_all();
    reg_sel = 0; reg_wr = 1; reg_wdata = '1;
    cycle("R11 clear");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    m_st = '0; m_ma = '0; m_ba = '0; m_req = 0; m_vec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 req", AW'(exc_req), '0);
    check("R1 vec", AW'(exc_vec), '0);
    check("R1 status", reg_rdata, '0);
    reg_sel = 1; #1 check("R1 maddr", reg_rdata, '0);
    reg_sel = 2; #1 check("R1 baddr", reg_rdata, '0);
    reg_sel = 3; #1 check("R13 sel3", reg_rdata, '0);
    reg_sel = 0;
    @(negedge clk);

    ev(8'h08, 32'h1000, "R3 mem disabled");
    check("R3 forced", AW'(reg_rdata[8]), 1);
    clear_all();
    en_mem = 1; en_bus = 1; en_usage = 1; prio_mem = 2; prio_bus = 3; prio_usage = 4; cur_prio = 5;
    ev(8'h08, 32'h2000, "R2 mem taken");
    check("R9 mem vec", AW'(exc_vec), 4);
    ev(8'h10, 32'h3000, "R2 bus taken");
    check("R9 bus vec", AW'(exc_vec), 5);
    ev(8'h01, 32'h0, "R2 usage taken");
    check("R9 usage vec", AW'(exc_vec), 6);
    clear_all();
    cur_prio = 3;
    ev(8'h10, 32'h4000, "R4 equal prio");
    check("R4 vec", AW'(exc_vec), 3);
    check("R4 forced", AW'(reg_rdata[8]), 1);
    cur_prio = 7;
    ev(8'h30, 32'h5000, "R5 vector fetch");
    check("R5 vec", AW'(exc_vec), 3);
    ev(8'h40, 32'h0, "R6 bkpt");
    check("R6 status", AW'(reg_rdata[6]), 1);
    ev(8'h80, 32'h0, "R6 svc");
    check("R6 svc status", AW'(reg_rdata[7]), 1);
    clear_all();
    trap_div = 0; trap_unal = 0;
    ev(8'h06, 32'h0, "R7 traps off");
    check("R7 req", AW'(exc_req), 0);
    check("R7 status", reg_rdata, 0);
    trap_div = 1;
    ev(8'h02, 32'h0, "R7 div on");
    check("R7 div vec", AW'(exc_vec), 6);
    fault_mask = 1;
    ev(8'h20, 32'h0, "R8 masked hard");
    check("R8 req", AW'(exc_req), 0);
    ev(8'h09, 32'h6000, "R8 mem still taken");
    check("R8 mem vec", AW'(exc_vec), 4);
    fault_mask = 0;
    ev(8'h19, 32'h7000, "R10 mem beats bus");
    check("R10 vec", AW'(exc_vec), 4);
    clear_all();
    ev(8'h08, 32'hAAAA, "R12 first");
    ev(8'h08, 32'hBBBB, "R12 second");
    reg_sel = 1; #1 check("R12 frozen", reg_rdata, 32'hAAAA);
    reg_sel = 0; reg_wr = 1; reg_wdata = 32'h200; ev_cause = 8'h08; ev_addr = 32'hCCCC;
    cycle("R11 clear with event");
    reg_sel = 1; #1 check("R12 recapture", reg_rdata, 32'hCCCC);
    reg_sel = 0; #1 check("R11 set wins", AW'(reg_rdata[9]), 1);

    for (int i = 0; i < 4000; i++) begin
      ev_cause = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      ev_addr = $urandom;
      en_mem = 1'($urandom); en_bus = 1'($urandom); en_usage = 1'($urandom);
      trap_div = 1'($urandom); trap_unal = 1'($urandom);
      fault_mask = ($urandom % 8 == 0);
      prio_mem = PW'($urandom); prio_bus = PW'($urandom); prio_usage = PW'($urandom);
      cur_prio = PW'($urandom);
      reg_sel = 2'($urandom);
      reg_wr = ($urandom % 6 == 0);
      reg_wdata = $urandom;
      cycle("R10 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule